// File: doc/BRIEF.md
# Cartridge Bank-Switching Mapper

This block sits between an 8-bit CPU bus with 16-bit addresses and a cartridge whose ROM and RAM are much larger than the CPU can see at once. Writes that the CPU aims at the read-only region (addresses below 0x8000) do not change ROM. They load a small set of control registers: a RAM gate, a ROM bank number written as a low byte and a separate high part, and a RAM bank number. The block turns each CPU address into a physical ROM address and, for the external-RAM window 0xA000–0xBFFF, into a physical RAM address. It serves reads and writes of the cartridge RAM from an internal storage model.

The ROM region is split in two. Addresses 0x0000–0x3FFF always point at ROM bank 0. Addresses 0x4000–0x7FFF point at the selected bank, and bank value 0 is allowed. Both physical addresses are wrapped by a power-of-two mask, with no bounds check. RAM traffic passes only while the gate holds its key. When the gate is closed, writes are dropped and reads return 0xFF without touching storage.

A one-register state machine records the class of the access seen at each clock edge. It drives the read-data outputs from that record.

States:
- ST_IDLE: no strobe, or a write above the ROM region that is not in the RAM window.
- ST_CTRL_WR: a control write.
- ST_RAM_WR: a RAM-window write.
- ST_RAM_RD: a gated-open RAM read.
- ST_RAM_RD_OFF: a RAM read while the gate is closed.
- ST_ROM_RD: any other read.

Every state can move to every other state. The next state depends only on the current strobes and address, and a write wins over a read. The response is presented in the cycle after the edge that recorded the access.

Top module: `cart_mapper`

## Requirements
- R1: After reset the ROM bank number is 1, the RAM bank number is 0 and the RAM gate is closed. With no writes, address 0x4000 maps to ROM byte 0x4000, and a RAM read returns 0xFF.
- R2: A write with address bits [15:12] equal to 0 or 1 opens the RAM gate when data bits [3:0] equal 0xA. The upper data nibble is ignored, so 0x3A also opens the gate. Any other low nibble closes the gate.
- R3: A write with address bits [15:12] equal to 2 loads ROM bank bits [7:0] from the data byte and leaves the upper bank bit unchanged.
- R4: A write with address bits [15:12] equal to 3 loads ROM bank bit 8 from data bit 0. The other data bits are dropped and bank bits [7:0] are unchanged.
- R5: A write with address bits [15:12] equal to 4 or 5 loads the RAM bank number from data bits [3:0] only.
- R6: `rom_addr` equals address bits [13:0] for CPU addresses 0x0000–0x3FFF. For CPU addresses 0x4000–0x7FFF it equals (bank × 0x4000 + address[13:0]) ANDed with 2^ROM_AW − 1. Bank 0 yields address[13:0].
- R7: `ram_addr` equals (address[12:0] + RAM bank × 0x2000) ANDed with 2^RAM_AW − 1. With default parameters, bank 5 and bank 1 reach the same bytes.
- R8: A read in 0xA000–0xBFFF with the gate open raises `ram_rvalid` in the next cycle. In that cycle `ram_rdata` holds the byte last written to the same storage location. Reads outside the window never raise `ram_rvalid`.
- R9: A read in the RAM window with the gate closed raises `ram_rvalid` in the next cycle with `ram_rdata` equal to 0xFF.
- R10: A write in the RAM window while the gate is closed leaves storage unchanged.
- R11: Writes with address bits [15:12] equal to 6 or 7, or at 0x8000 and above outside the RAM window, change no control register.
- R12: Storage holds the bank bits of the physical RAM address and its low OFS_AW offset bits. Offsets that differ only in bits OFS_AW..12 share a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | write strobe, one access per asserted cycle |
| cpu_rd | input | 1 | read strobe, one access per asserted cycle |
| rom_addr | output | ROM_AW | physical ROM byte address, combinational |
| ram_addr | output | RAM_AW | physical RAM byte address, combinational |
| ram_rdata | output | 8 | RAM read data, valid with ram_rvalid |
| ram_rvalid | output | 1 | a RAM-window read result is presented |

## Verification
The two physical addresses are combinational. The bench therefore compares them a fraction of a nanosecond after it drives the address, in the same cycle, and drives control writes one full cycle before looking at their effect. Read data is due exactly one cycle after the read strobe is sampled. Each queued expectation carries its due cycle number, and the monitor compares at the falling edge of that cycle, so a late, early or missing `ram_rvalid` counts as a failure. The effects of ignored writes are observed through later address translation and through RAM read-back.

// File: rtl/cart_pkg.sv
package cart_pkg;

    // class of the access recorded at a clock edge
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL_WR,
        ST_RAM_WR,
        ST_RAM_RD,
        ST_RAM_RD_OFF,
        ST_ROM_RD
    } bus_state_e;

    // control register picked by a write below 0x8000
    typedef enum logic [2:0] {
        CSEL_GATE,
        CSEL_ROM_LO,
        CSEL_ROM_HI,
        CSEL_RAM_BANK,
        CSEL_NONE
    } ctrl_sel_e;

    localparam logic [3:0] GATE_KEY   = 4'hA;
    localparam int         ROM_OFS_AW = 14;
    localparam int         RAM_OFS_AW = 13;

    function automatic ctrl_sel_e ctrl_decode(input logic [3:0] nib);
        ctrl_sel_e s;
        unique case (nib)
            4'h0, 4'h1: s = CSEL_GATE;
            4'h2:       s = CSEL_ROM_LO;
            4'h3:       s = CSEL_ROM_HI;
            4'h4, 4'h5: s = CSEL_RAM_BANK;
            default:    s = CSEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/cart_regs.sv
module cart_regs
    import cart_pkg::*;
#(
    parameter int ROM_BANK_W = 9,
    parameter int RAM_BANK_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [3:0]            nib,
    input  logic [7:0]            wdata,
    output logic                  ram_en,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic [RAM_BANK_W-1:0] ram_bank
);
    localparam int HI_W = ROM_BANK_W - 8;

    ctrl_sel_e sel;
    assign sel = ctrl_decode(nib);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_en   <= 1'b0;
            rom_bank <= ROM_BANK_W'(1);
            ram_bank <= '0;
        end else if (wr_en) begin
            unique case (sel)
                CSEL_GATE:     ram_en        <= (wdata[3:0] == GATE_KEY);
                CSEL_ROM_LO:   rom_bank[7:0] <= wdata;
                CSEL_ROM_HI:   rom_bank[ROM_BANK_W-1:8] <= wdata[HI_W-1:0];
                CSEL_RAM_BANK: ram_bank      <= wdata[RAM_BANK_W-1:0];
                CSEL_NONE:     ;
                default:       ;
            endcase
        end
    end

    // R2
    a_r2_gate_key: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && nib[3:1] == 3'b000) |=> (ram_en == ($past(wdata[3:0]) == 4'hA)));

    // R3
    a_r3_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && nib == 4'h2) |=> (rom_bank[7:0] == $past(wdata)
            && rom_bank[ROM_BANK_W-1:8] == $past(rom_bank[ROM_BANK_W-1:8])));

    // R4
    a_r4_high_part: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && nib == 4'h3) |=> (rom_bank[ROM_BANK_W-1:8] == $past(wdata[HI_W-1:0])
            && rom_bank[7:0] == $past(rom_bank[7:0])));

    // R5
    a_r5_ram_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && nib[3:1] == 3'b010) |=> (ram_bank == $past(wdata[RAM_BANK_W-1:0])));

    // R11
    a_r11_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || nib[3:1] == 3'b011) |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_en)));

endmodule

// File: rtl/cart_xlate.sv
module cart_xlate
    import cart_pkg::*;
#(
    parameter int ROM_BANK_W = 9,
    parameter int RAM_BANK_W = 4,
    parameter int ROM_AW     = 23,
    parameter int RAM_AW     = 15
) (
    input  logic [15:0]           cpu_addr,
    input  logic [ROM_BANK_W-1:0] rom_bank,
    input  logic [RAM_BANK_W-1:0] ram_bank,
    output logic                  in_ram_win,
    output logic [ROM_AW-1:0]     rom_addr,
    output logic [RAM_AW-1:0]     ram_addr
);
    localparam int ROM_FULL_W = ROM_BANK_W + ROM_OFS_AW;
    localparam int RAM_FULL_W = RAM_BANK_W + RAM_OFS_AW;

    logic [ROM_BANK_W-1:0] eff_bank;
    logic [ROM_FULL_W-1:0] rom_full;
    logic [RAM_FULL_W-1:0] ram_full;

    // lower 16 KiB always bank 0, upper 16 KiB the selected bank
    assign eff_bank   = cpu_addr[14] ? rom_bank : '0;
    assign rom_full   = {eff_bank, cpu_addr[ROM_OFS_AW-1:0]};
    // bank * 8 KiB + offset; the low bits of the product are zero
    assign ram_full   = {ram_bank, cpu_addr[RAM_OFS_AW-1:0]};
    assign in_ram_win = (cpu_addr[15:13] == 3'b101);

    // wrap by power-of-two mask, or widen when the space is larger
    generate
        if (ROM_AW <= ROM_FULL_W) begin : g_rom_wrap
            assign rom_addr = rom_full[ROM_AW-1:0];
        end else begin : g_rom_wide
            assign rom_addr = {{(ROM_AW-ROM_FULL_W){1'b0}}, rom_full};
        end
        if (RAM_AW <= RAM_FULL_W) begin : g_ram_wrap
            assign ram_addr = ram_full[RAM_AW-1:0];
        end else begin : g_ram_wide
            assign ram_addr = {{(RAM_AW-RAM_FULL_W){1'b0}}, ram_full};
        end
    endgenerate

endmodule

// File: rtl/cart_ram.sv
module cart_ram
    import cart_pkg::*;
#(
    parameter int RAM_AW = 15,
    parameter int OFS_AW = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [RAM_AW-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int BANK_BITS = RAM_AW - RAM_OFS_AW;
    localparam int IDX_W     = BANK_BITS + OFS_AW;
    localparam int DEPTH     = 1 << IDX_W;

    logic [7:0]       store [DEPTH];
    logic [IDX_W-1:0] idx;

    // keep bank bits and the low offset bits of the physical address
    generate
        if (BANK_BITS > 0) begin : g_banked
            assign idx = {addr[RAM_AW-1:RAM_OFS_AW], addr[OFS_AW-1:0]};
        end else begin : g_flat
            assign idx = addr[OFS_AW-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (we) begin
            store[idx] <= wdata;
        end
        if (re) begin
            rdata <= store[idx];
        end
    end

endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
    import cart_pkg::*;
#(
    parameter int ROM_BANK_W = 9,
    parameter int RAM_BANK_W = 4,
    parameter int ROM_AW     = 23,
    parameter int RAM_AW     = 15,
    parameter int OFS_AW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [7:0]        ram_rdata,
    output logic              ram_rvalid
);
    bus_state_e            state_q, state_d;
    logic                  ram_en;
    logic [ROM_BANK_W-1:0] rom_bank;
    logic [RAM_BANK_W-1:0] ram_bank;
    logic                  in_ram_win;
    logic                  ctrl_wr;
    logic                  mem_we;
    logic                  mem_re;
    logic [7:0]            mem_q;

    assign ctrl_wr = cpu_wr && !cpu_addr[15];
    assign mem_we  = cpu_wr && in_ram_win && ram_en;
    assign mem_re  = !cpu_wr && cpu_rd && in_ram_win && ram_en;

    cart_regs #(
        .ROM_BANK_W (ROM_BANK_W),
        .RAM_BANK_W (RAM_BANK_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctrl_wr),
        .nib      (cpu_addr[15:12]),
        .wdata    (cpu_wdata),
        .ram_en   (ram_en),
        .rom_bank (rom_bank),
        .ram_bank (ram_bank)
    );

    cart_xlate #(
        .ROM_BANK_W (ROM_BANK_W),
        .RAM_BANK_W (RAM_BANK_W),
        .ROM_AW     (ROM_AW),
        .RAM_AW     (RAM_AW)
    ) u_xlate (
        .cpu_addr   (cpu_addr),
        .rom_bank   (rom_bank),
        .ram_bank   (ram_bank),
        .in_ram_win (in_ram_win),
        .rom_addr   (rom_addr),
        .ram_addr   (ram_addr)
    );

    cart_ram #(
        .RAM_AW (RAM_AW),
        .OFS_AW (OFS_AW)
    ) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (ram_addr),
        .wdata (cpu_wdata),
        .rdata (mem_q)
    );

    // next state: class of the current access, write before read
    always_comb begin
        state_d = ST_IDLE;
        if (cpu_wr) begin
            if (!cpu_addr[15])    state_d = ST_CTRL_WR;
            else if (in_ram_win)  state_d = ST_RAM_WR;
            else                  state_d = ST_IDLE;
        end else if (cpu_rd) begin
            if (in_ram_win)       state_d = ram_en ? ST_RAM_RD : ST_RAM_RD_OFF;
            else                  state_d = ST_ROM_RD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ram_rvalid = 1'b0;
        ram_rdata  = 8'hFF;
        unique case (state_q)
            ST_RAM_RD: begin
                ram_rvalid = 1'b1;
                ram_rdata  = mem_q;
            end
            ST_RAM_RD_OFF: begin
                ram_rvalid = 1'b1;
                ram_rdata  = 8'hFF;
            end
            ST_IDLE, ST_CTRL_WR, ST_RAM_WR, ST_ROM_RD: ;
            default: ;
        endcase
    end

    // R8
    a_r8_read_due: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && cpu_addr[15:13] == 3'b101) |=> ram_rvalid);

    // R8: nothing outside the window produces read data
    a_r8_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cpu_rd && !cpu_wr && cpu_addr[15:13] == 3'b101)) |=> !ram_rvalid);

    // R9
    a_r9_closed_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && cpu_addr[15:13] == 3'b101 && !ram_en) |=> (ram_rdata == 8'hFF));

endmodule

// File: tb/cart_mapper_test.sv
`timescale 1ns/1ps
module cart_mapper_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [22:0] rom_addr;
    logic [14:0] ram_addr;
    logic [7:0]  ram_rdata;
    logic        ram_rvalid;

    always #2 clk = ~clk;

    cart_mapper uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_wr     (cpu_wr),
        .cpu_rd     (cpu_rd),
        .rom_addr   (rom_addr),
        .ram_addr   (ram_addr),
        .ram_rdata  (ram_rdata),
        .ram_rvalid (ram_rvalid)
    );

    typedef struct {
        int         due;
        logic [7:0] exp;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    int         n_chk = 0;
    int         n_err = 0;
    int         cyc = 0;
    bit         done = 0;

    // reference model, built from the requirements
    logic [8:0] m_rom = 9'd1;
    logic [3:0] m_ram = 4'd0;
    bit         m_en = 0;
    logic [7:0] m_mem [1024];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [14:0] ram_phys(input logic [15:0] a);
        return 15'((32'(a[12:0]) + 32'(m_ram) * 32'h2000) & 32'h7FFF);
    endfunction

    function automatic logic [22:0] rom_phys(input logic [15:0] a);
        if (!a[14]) return 23'(a[13:0]);
        return 23'(((32'(m_rom) << 14) + 32'(a[13:0])) & 32'h7F_FFFF);
    endfunction

    function automatic int midx(input logic [14:0] p);
        return int'({p[14:13], p[7:0]});
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        if (!a[15]) begin
            case (a[15:12])
                4'h0, 4'h1: m_en = (d[3:0] == 4'hA);
                4'h2: m_rom[7:0] = d;
                4'h3: m_rom[8] = d[0];
                4'h4, 4'h5: m_ram = d[3:0];
                default: ;
            endcase
        end else if (a[15:13] == 3'b101 && m_en) begin
            m_mem[midx(ram_phys(a))] = d;
        end
        @(posedge clk);
        #1 cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input string tag);
        exp_t e;
        @(negedge clk);
        cpu_addr = a; cpu_wr = 1'b0; cpu_rd = 1'b1;
        if (a[15:13] == 3'b101) begin
            e.due = cyc + 1;
            e.exp = m_en ? m_mem[midx(ram_phys(a))] : 8'hFF;
            e.tag = tag;
            sb.push_back(e);
        end
        @(posedge clk);
        #1 cpu_rd = 1'b0;
    endtask

    task automatic peek(input logic [15:0] a, input string tag);
        @(negedge clk);
        cpu_addr = a; cpu_wr = 1'b0; cpu_rd = 1'b0;
        #0.5;
        chk({tag, " rom_addr"}, 32'(rom_addr), 32'(rom_phys(a)));
        chk({tag, " ram_addr"}, 32'(ram_addr), 32'(ram_phys(a)));
    endtask

    // monitor: pops expectations as results come due
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ram_rvalid) begin
                if (sb.size() == 0) begin
                    n_chk++; n_err++;
                    $display("FAIL R8 stray ram_rvalid actual=1 expected=0");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk({e.tag, " due cycle"}, 32'(cyc), 32'(e.due));
                    chk({e.tag, " ram_rdata"}, 32'(ram_rdata), 32'(e.exp));
                end
            end else if (sb.size() != 0 && sb[0].due <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++; n_err++;
                $display("FAIL %s ram_rvalid missing actual=0 expected=1", e.tag);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        peek(16'h4000, "R1 bank1 after reset");
        rd(16'hA000, "R1 gate closed after reset");

        // R6 fixed and switched ROM regions
        peek(16'h0123, "R6 bank0 region");
        peek(16'h7FFF, "R6 top of switched region");
        rd(16'h4000, "R8 ROM read, no rvalid");

        // R2, R7, R8 open gate, bank offset
        wr(16'h0000, 8'h0A);
        wr(16'hA005, 8'h11);
        wr(16'h4000, 8'h01);
        wr(16'hA005, 8'h22);
        peek(16'hA005, "R7 bank1 offset");
        rd(16'hA005, "R8 read bank1");
        wr(16'h4000, 8'h00);
        rd(16'hA005, "R8 read bank0");

        // R5 low nibble only, R7 wrap by mask
        wr(16'h4000, 8'hF3);
        peek(16'hBFFF, "R5 R7 bank3 top");
        wr(16'h5000, 8'h05);
        peek(16'hA100, "R7 bank5 wraps");
        wr(16'hA100, 8'h5A);
        wr(16'h4000, 8'h01);
        rd(16'hA100, "R7 bank5 aliases bank1");

        // R12 storage aliasing of offsets
        wr(16'hA234, 8'hC3);
        rd(16'hA034, "R12 offset alias");

        // R3, R4 two-part ROM bank
        wr(16'h2000, 8'h05);
        peek(16'h4000, "R3 low byte");
        wr(16'h3000, 8'h03);
        peek(16'h4000, "R4 high part");
        wr(16'h2FFF, 8'h07);
        peek(16'h4001, "R3 keeps high part");
        wr(16'h3000, 8'h00);
        peek(16'h4000, "R4 keeps low byte");
        wr(16'h2000, 8'h00);
        peek(16'h4ABC, "R6 bank value 0");

        // R11 ignored writes
        wr(16'h6000, 8'hFF);
        wr(16'h7FFF, 8'h01);
        wr(16'h8000, 8'h55);
        wr(16'hC000, 8'h33);
        peek(16'h4ABC, "R11 ROM bank kept");
        peek(16'hA000, "R11 RAM bank kept");
        rd(16'hA100, "R11 gate kept open");

        // R10, R9, R2 gate behaviour
        wr(16'hA010, 8'h77);
        wr(16'h1000, 8'h00);
        wr(16'hA010, 8'h99);
        rd(16'hA010, "R9 closed gate reads FF");
        wr(16'h1FFF, 8'h3A);
        rd(16'hA010, "R10 closed write ignored");
        wr(16'h0000, 8'h0B);
        rd(16'hBFFF, "R2 key mismatch closes");

        repeat (4) @(negedge clk);
        n_chk++;
        if (sb.size() != 0) begin
            n_err++;
            $display("FAIL R8 pending results actual=%0d expected=0", sb.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule